// File: doc/BRIEF.md
# Predicate Logical Operation Unit

This unit carries out one 32-bit predicate logical instruction for each accepted request. It holds a file of 16 predicate registers and decodes the instruction into a destination, two source operands, a governing predicate and a function. It then computes one of eight bitwise functions and writes the result back. Seven of the functions combine the two sources and then keep only the bits where the governing predicate is set. The eighth is a per-bit select: where the governing bit is set it takes the first source, and elsewhere it takes the second.

The instruction word has a flag-setting variant. In that form the unit also derives four condition flags from the new result, evaluated over the governing predicate as it stood before the write-back. Each register is `PRED_BITS` wide in storage, and only the low `PRED_LEN` bits are live (one bit per vector byte). A debug write port preloads registers. Results appear as a one-cycle pulse the cycle after acceptance. Malformed or unallocated encodings raise a one-cycle illegal strobe instead.

Top module: `pred_logic_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, all registers read as zero, the flags are zero, and `res_valid`, `flags_valid` and `illegal` are low. `in_ready` is low during reset and high from the first cycle after it.
- R2: Fields are decoded at these positions: destination [3:0], first source [8:5], governing [13:10], second source [19:16], flag-set S = bit 22. The function code is {bit 23, bit 9, bit 4}. An instruction accepted in cycle t gives `res_valid` = 1 with `res_dst` and `res_data` in cycle t+1, and no pulse in cycle t+1 follows a cycle without acceptance.
- R3: The masked function codes compute, for each bit: 000 (n&m)&g, 001 (n&~m)&g, 010 (n^m)&g, 100 (n|m)&g, 101 (n|~m)&g, 110 ~(n|m)&g, 111 ~(n&m)&g.
- R4: Code 011 is a select: the result bit is n where g is 1 and m where g is 0, with no further masking.
- R5: A word whose bits [31:24] are not 8'h25, whose bits [21:20] are not 00, or whose bits [15:14] are not 01 gives `illegal` = 1 in cycle t+1. It writes no register and leaves the flags unchanged.
- R6: Code 011 with S = 1 is illegal. It writes no register and leaves the flags unchanged.
- R7: With S = 1, the flags update in cycle t+1 and `flags_valid` pulses. N is the result bit at the lowest active position (where g = 1). Z is 1 when no active bit of the result is 1. C is 1 when the result bit at the highest active position is 0. V is 0. With no active bit the flags are N=0, Z=1, C=1. With S = 0, the flags hold.
- R8: When the destination is also the governing register, the flags use the governing value read before the write.
- R9: Bits at index `PRED_LEN` and above are zero in every result and stored value, including debug writes.
- R10: Back-to-back instructions see each other's results: a source read in the cycle that follows a write-back's acceptance gets the new value.
- R11: A debug write (`dbg_we`) replaces the named register at the clock edge. Instructions accepted afterwards read the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction request |
| in_ready | output | 1 | Unit accepts a request this cycle |
| in_insn | input | 32 | Instruction word |
| dbg_we | input | 1 | Debug register write enable |
| dbg_idx | input | 4 | Debug write register index |
| dbg_data | input | PRED_BITS | Debug write value |
| res_valid | output | 1 | Result pulse |
| res_dst | output | 4 | Destination register of the result |
| res_data | output | PRED_BITS | Result value |
| flags_valid | output | 1 | Flags updated this cycle |
| flag_n | output | 1 | Negative / first-active flag |
| flag_z | output | 1 | Zero / none-active flag |
| flag_c | output | 1 | Carry / not-last-active flag |
| flag_v | output | 1 | Overflow flag, always zero |
| illegal | output | 1 | Illegal-instruction strobe |

## Verification
The bench builds the unit with `PRED_BITS` = 32 and `PRED_LEN` = 24. This leaves eight dead bits above the live length in every register, so the zeroing of high bits is visible. It is most visible after the inverting functions and after debug writes that set all 32 bits. The short length also keeps governing predicates with no active bit, or with a single active bit at either end, easy to produce. The flag corner cases are thus within reach alongside the destination-equals-governing and back-to-back forwarding orderings.

// File: rtl/pred_logic_pkg.sv
// Shared types for the predicate logical operation unit.
// Assumes a 4-bit register index (16 predicate registers).
package pred_logic_pkg;

    localparam int unsigned PL_IDX_W   = 4;
    localparam int unsigned PL_NUM_REG = 1 << PL_IDX_W;

    typedef enum logic [2:0] {
        FN_AND  = 3'b000,
        FN_BIC  = 3'b001,
        FN_EOR  = 3'b010,
        FN_SEL  = 3'b011,
        FN_ORR  = 3'b100,
        FN_ORN  = 3'b101,
        FN_NOR  = 3'b110,
        FN_NAND = 3'b111
    } pl_func_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } pl_flags_t;

    typedef struct packed {
        logic                legal;
        logic                set_flags;
        pl_func_e            func;
        logic [PL_IDX_W-1:0] dst;
        logic [PL_IDX_W-1:0] src_n;
        logic [PL_IDX_W-1:0] src_m;
        logic [PL_IDX_W-1:0] gov;
    } pl_dec_t;

endpackage

// File: rtl/pred_insn_decode.sv
// Instruction decoder: splits a 32-bit word into register fields,
// function code and flag-set bit, and judges whether it is allocated.
// Assumes: purely combinational, no state.
module pred_insn_decode
    import pred_logic_pkg::*;
(
    input  logic [31:0] insn,
    output pl_dec_t     dec
);

    localparam logic [7:0] TOP_PATTERN = 8'h25;
    localparam logic [1:0] MID_PATTERN = 2'b00;
    localparam logic [1:0] LOW_PATTERN = 2'b01;

    logic fixed_ok;
    logic sel_with_flags;

    // Check the constant fields and the one unallocated combination.
    always_comb begin
        fixed_ok       = (insn[31:24] == TOP_PATTERN) &&
                         (insn[21:20] == MID_PATTERN) &&
                         (insn[15:14] == LOW_PATTERN);
        sel_with_flags = insn[22] && ({insn[23], insn[9], insn[4]} == FN_SEL);
    end

    // Extract the fields.
    always_comb begin
        dec.legal     = fixed_ok && !sel_with_flags;
        dec.set_flags = insn[22];
        dec.func      = pl_func_e'({insn[23], insn[9], insn[4]});
        dec.dst       = insn[3:0];
        dec.src_n     = insn[8:5];
        dec.src_m     = insn[19:16];
        dec.gov       = insn[13:10];
    end

endmodule

// File: rtl/pred_regfile.sv
// Predicate register file: 16 registers, three combinational read ports
// with forwarding from the pending write-back, one write-back port and
// one debug write port (debug wins on a same-edge collision).
// Assumes: bits at and above PRED_LEN are cleared on every write.
module pred_regfile
    import pred_logic_pkg::*;
#(
    parameter int unsigned PRED_BITS = 32,
    parameter int unsigned PRED_LEN  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PL_IDX_W-1:0]  rd_idx_n,
    input  logic [PL_IDX_W-1:0]  rd_idx_m,
    input  logic [PL_IDX_W-1:0]  rd_idx_g,
    output logic [PRED_BITS-1:0] rd_data_n,
    output logic [PRED_BITS-1:0] rd_data_m,
    output logic [PRED_BITS-1:0] rd_data_g,
    input  logic                 wb_en,
    input  logic [PL_IDX_W-1:0]  wb_idx,
    input  logic [PRED_BITS-1:0] wb_data,
    input  logic                 dbg_we,
    input  logic [PL_IDX_W-1:0]  dbg_idx,
    input  logic [PRED_BITS-1:0] dbg_data
);

    localparam logic [PRED_BITS-1:0] LEN_MASK = {PRED_BITS{1'b1}} >> (PRED_BITS - PRED_LEN);

    logic [PRED_BITS-1:0] regs [PL_NUM_REG];

    for (genvar k = 0; k < PL_NUM_REG; k++) begin : g_reg
        // Hold one register; debug write takes priority over write-back.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[k] <= '0;
            end else if (dbg_we && (dbg_idx == PL_IDX_W'(k))) begin
                regs[k] <= dbg_data & LEN_MASK;
            end else if (wb_en && (wb_idx == PL_IDX_W'(k))) begin
                regs[k] <= wb_data & LEN_MASK;
            end
        end
    end

    function automatic logic [PRED_BITS-1:0] fwd_read(input logic [PL_IDX_W-1:0] idx);
        if (wb_en && (wb_idx == idx)) begin
            return wb_data & LEN_MASK;
        end
        return regs[idx];
    endfunction

    // Read the three operands, forwarding the pending write-back.
    always_comb begin
        rd_data_n = fwd_read(rd_idx_n);
        rd_data_m = fwd_read(rd_idx_m);
        rd_data_g = fwd_read(rd_idx_g);
    end

endmodule

// File: rtl/pred_logic_alu.sv
// Logic and flag stage: computes the selected governed bitwise function
// and the condition flags over the live PRED_LEN bits.
// Assumes: operands already have their dead bits cleared.
module pred_logic_alu
    import pred_logic_pkg::*;
#(
    parameter int unsigned PRED_BITS = 32,
    parameter int unsigned PRED_LEN  = 32
) (
    input  pl_func_e             func,
    input  logic [PRED_BITS-1:0] op_n,
    input  logic [PRED_BITS-1:0] op_m,
    input  logic [PRED_BITS-1:0] op_g,
    output logic [PRED_BITS-1:0] result,
    output pl_flags_t            flags
);

    localparam logic [PRED_BITS-1:0] LEN_MASK = {PRED_BITS{1'b1}} >> (PRED_BITS - PRED_LEN);

    logic [PRED_BITS-1:0] raw;

    // Pick the bitwise function; the select variant bypasses the mask.
    always_comb begin
        unique case (func)
            FN_AND:  raw = (op_n & op_m) & op_g;
            FN_BIC:  raw = (op_n & ~op_m) & op_g;
            FN_EOR:  raw = (op_n ^ op_m) & op_g;
            FN_SEL:  raw = (op_n & op_g) | (op_m & ~op_g);
            FN_ORR:  raw = (op_n | op_m) & op_g;
            FN_ORN:  raw = (op_n | ~op_m) & op_g;
            FN_NOR:  raw = ~(op_n | op_m) & op_g;
            FN_NAND: raw = ~(op_n & op_m) & op_g;
            default: raw = '0;
        endcase
        result = raw & LEN_MASK;
    end

    logic first_seen;
    logic first_bit;
    logic last_bit;

    // Scan the active lanes for the first and last result bits.
    always_comb begin
        first_seen = 1'b0;
        first_bit  = 1'b0;
        last_bit   = 1'b0;
        for (int i = 0; i < int'(PRED_LEN); i++) begin
            if (op_g[i]) begin
                if (!first_seen) begin
                    first_bit = result[i];
                end
                first_seen = 1'b1;
                last_bit   = result[i];
            end
        end
    end

    // Assemble the flag word.
    always_comb begin
        flags.n = first_bit;
        flags.z = ~|(result & op_g & LEN_MASK);
        flags.c = ~last_bit;
        flags.v = 1'b0;
    end

endmodule

// File: rtl/pred_logic_unit.sv
// Top of the predicate logical operation unit. Accepts one instruction
// per cycle, reads operands in the accept cycle, registers the result,
// flags and strobes on the next edge, and writes the register file one
// edge later (reads in between are forwarded).
// Assumes: PRED_LEN <= PRED_BITS; synchronous active-low reset.
module pred_logic_unit
    import pred_logic_pkg::*;
#(
    parameter int unsigned PRED_BITS = 32,
    parameter int unsigned PRED_LEN  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [31:0]          in_insn,
    input  logic                 dbg_we,
    input  logic [3:0]           dbg_idx,
    input  logic [PRED_BITS-1:0] dbg_data,
    output logic                 res_valid,
    output logic [3:0]           res_dst,
    output logic [PRED_BITS-1:0] res_data,
    output logic                 flags_valid,
    output logic                 flag_n,
    output logic                 flag_z,
    output logic                 flag_c,
    output logic                 flag_v,
    output logic                 illegal
);

    pl_dec_t              dec;
    logic [PRED_BITS-1:0] val_n, val_m, val_g;
    logic [PRED_BITS-1:0] alu_res;
    pl_flags_t            alu_flags;
    logic                 accept;

    logic                 ready_q;
    logic                 res_valid_q;
    logic [PL_IDX_W-1:0]  res_dst_q;
    logic [PRED_BITS-1:0] res_data_q;
    logic                 flags_valid_q;
    pl_flags_t            flags_q;
    logic                 illegal_q;

    pred_insn_decode u_dec (
        .insn (in_insn),
        .dec  (dec)
    );

    pred_regfile #(
        .PRED_BITS (PRED_BITS),
        .PRED_LEN  (PRED_LEN)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx_n  (dec.src_n),
        .rd_idx_m  (dec.src_m),
        .rd_idx_g  (dec.gov),
        .rd_data_n (val_n),
        .rd_data_m (val_m),
        .rd_data_g (val_g),
        .wb_en     (res_valid_q),
        .wb_idx    (res_dst_q),
        .wb_data   (res_data_q),
        .dbg_we    (dbg_we),
        .dbg_idx   (dbg_idx),
        .dbg_data  (dbg_data)
    );

    pred_logic_alu #(
        .PRED_BITS (PRED_BITS),
        .PRED_LEN  (PRED_LEN)
    ) u_alu (
        .func   (dec.func),
        .op_n   (val_n),
        .op_m   (val_m),
        .op_g   (val_g),
        .result (alu_res),
        .flags  (alu_flags)
    );

    // Handshake: a request is taken whenever the unit is out of reset.
    assign accept = in_valid && ready_q;

    // Ready register: low in reset, high afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else begin
            ready_q <= 1'b1;
        end
    end

    // Result stage: capture the result and strobes of the accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_q <= 1'b0;
            res_dst_q   <= '0;
            res_data_q  <= '0;
            illegal_q   <= 1'b0;
        end else begin
            res_valid_q <= accept && dec.legal;
            illegal_q   <= accept && !dec.legal;
            if (accept && dec.legal) begin
                res_dst_q  <= dec.dst;
                res_data_q <= alu_res;
            end
        end
    end

    // Flag stage: update only for legal flag-setting words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q       <= '0;
            flags_valid_q <= 1'b0;
        end else begin
            flags_valid_q <= accept && dec.legal && dec.set_flags;
            if (accept && dec.legal && dec.set_flags) begin
                flags_q <= alu_flags;
            end
        end
    end

    // Drive the outputs from the registered stage.
    always_comb begin
        in_ready    = ready_q;
        res_valid   = res_valid_q;
        res_dst     = res_dst_q;
        res_data    = res_data_q;
        flags_valid = flags_valid_q;
        flag_n      = flags_q.n;
        flag_z      = flags_q.z;
        flag_c      = flags_q.c;
        flag_v      = flags_q.v;
        illegal     = illegal_q;
    end

endmodule

// File: rtl/pred_logic_chk.sv
// Checker for the predicate logical operation unit, bound to the top.
// Assumes: observes ports only.
module pred_logic_chk #(
    parameter int unsigned PRED_BITS = 32,
    parameter int unsigned PRED_LEN  = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 res_valid,
    input logic [PRED_BITS-1:0] res_data,
    input logic                 flags_valid,
    input logic                 flag_n,
    input logic                 flag_z,
    input logic                 flag_c,
    input logic                 flag_v,
    input logic                 illegal
);

    localparam logic [PRED_BITS-1:0] LEN_MASK = {PRED_BITS{1'b1}} >> (PRED_BITS - PRED_LEN);

    assert_accept_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (res_valid || illegal));

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> (!res_valid && !illegal));

    assert_illegal_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!res_valid && !flags_valid));

    assert_flags_with_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flags_valid |-> res_valid);

    assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_valid |-> $stable({flag_n, flag_z, flag_c, flag_v}));

    assert_v_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flags_valid |-> !flag_v);

    assert_n_implies_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_valid && flag_n) |-> !flag_z);

    assert_dead_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_data & ~LEN_MASK) == '0));

endmodule

bind pred_logic_unit pred_logic_chk #(
    .PRED_BITS (PRED_BITS),
    .PRED_LEN  (PRED_LEN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .flags_valid (flags_valid),
    .flag_n      (flag_n),
    .flag_z      (flag_z),
    .flag_c      (flag_c),
    .flag_v      (flag_v),
    .illegal     (illegal)
);

// File: tb/tb_pred_logic_unit.sv
module tb_pred_logic_unit;

    localparam int CLK_PERIOD = 10;
    localparam int PB = 32;
    localparam int PL = 24;
    localparam logic [PB-1:0] MASK = {PB{1'b1}} >> (PB - PL);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [31:0]   in_insn = '0;
    logic          dbg_we = 1'b0;
    logic [3:0]    dbg_idx = '0;
    logic [PB-1:0] dbg_data = '0;
    logic          in_ready, res_valid, flags_valid, illegal;
    logic          flag_n, flag_z, flag_c, flag_v;
    logic [3:0]    res_dst;
    logic [PB-1:0] res_data;

    pred_logic_unit #(.PRED_BITS(PB), .PRED_LEN(PL)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_insn(in_insn), .dbg_we(dbg_we), .dbg_idx(dbg_idx), .dbg_data(dbg_data),
        .res_valid(res_valid), .res_dst(res_dst), .res_data(res_data),
        .flags_valid(flags_valid), .flag_n(flag_n), .flag_z(flag_z),
        .flag_c(flag_c), .flag_v(flag_v), .illegal(illegal)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_tag = "R1";
    bit    chk_en  = 1'b0;

    // Reference model state
    logic [PB-1:0] mreg [16];
    logic [3:0]    mflags = '0;
    logic          e_ready = 0, e_rv = 0, e_fv = 0, e_ill = 0;
    logic [3:0]    e_dst = '0;
    logic [PB-1:0] e_data = '0;

    function automatic logic [31:0] mk(input int f, input bit s, input int d,
                                       input int n, input int m, input int g);
        logic [2:0] fc = 3'(f);
        return {8'h25, fc[2], s, 2'b00, 4'(m), 2'b01, 4'(g), fc[1], 4'(n), fc[0], 4'(d)};
    endfunction

    task automatic model_exec(input logic [31:0] w);
        logic [2:0]    f;
        logic [PB-1:0] n, m, g, r;
        bit            fixed, seen, fn, lb;
        fixed = (w[31:24] == 8'h25) && (w[21:20] == 2'b00) && (w[15:14] == 2'b01);
        f = {w[23], w[9], w[4]};
        if (!fixed || (f == 3'd3 && w[22])) begin
            e_ill = 1;
            return;
        end
        n = mreg[w[8:5]]; m = mreg[w[19:16]]; g = mreg[w[13:10]];
        r = '0;
        for (int b = 0; b < PL; b++) begin
            case (f)
                3'd0: r[b] = n[b] & m[b] & g[b];
                3'd1: r[b] = n[b] & !m[b] & g[b];
                3'd2: r[b] = (n[b] != m[b]) & g[b];
                3'd3: r[b] = g[b] ? n[b] : m[b];
                3'd4: r[b] = (n[b] | m[b]) & g[b];
                3'd5: r[b] = (n[b] | !m[b]) & g[b];
                3'd6: r[b] = !(n[b] | m[b]) & g[b];
                default: r[b] = !(n[b] & m[b]) & g[b];
            endcase
        end
        seen = 0; fn = 0; lb = 0;
        for (int b = 0; b < PL; b++) begin
            if (g[b]) begin
                if (!seen) fn = r[b];
                seen = 1;
                lb = r[b];
            end
        end
        mreg[w[3:0]] = r;
        e_rv = 1; e_dst = w[3:0]; e_data = r;
        if (w[22]) begin
            mflags = {fn, ((r & g) == '0), !lb, 1'b0};
            e_fv = 1;
        end
    endtask

    // Reference model, advanced on every clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 16; k++) mreg[k] = '0;
            mflags = '0; e_rv = 0; e_fv = 0; e_ill = 0; e_ready = 0;
        end else begin
            e_rv = 0; e_fv = 0; e_ill = 0;
            if (in_valid && e_ready) model_exec(in_insn);
            if (dbg_we) mreg[dbg_idx] = dbg_data & MASK;
            e_ready = 1;
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (chk_en) begin
            bit bad = 0;
            n_tests++;
            if (in_ready !== e_ready || res_valid !== e_rv || illegal !== e_ill ||
                flags_valid !== e_fv) bad = 1;
            if (e_rv && (res_dst !== e_dst || res_data !== e_data)) bad = 1;
            if ({flag_n, flag_z, flag_c, flag_v} !== mflags) bad = 1;
            if (bad) begin
                n_fail++;
                $display("FAIL %s: rdy=%b rv=%b ill=%b fv=%b dst=%0d data=%h nzcv=%b | exp rdy=%b rv=%b ill=%b fv=%b dst=%0d data=%h nzcv=%b",
                         cur_tag, in_ready, res_valid, illegal, flags_valid, res_dst, res_data,
                         {flag_n, flag_z, flag_c, flag_v}, e_ready, e_rv, e_ill, e_fv,
                         e_dst, e_data, mflags);
            end
        end
    end

    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1; in_insn = w; dbg_we = 0;
    endtask

    task automatic idle(input int c);
        repeat (c) begin
            @(negedge clk);
            in_valid = 0; dbg_we = 0;
        end
    endtask

    task automatic preload(input int idx, input logic [PB-1:0] v);
        @(negedge clk);
        in_valid = 0; dbg_we = 1; dbg_idx = 4'(idx); dbg_data = v;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while held
        n_tests++;
        if (in_ready !== 0 || res_valid !== 0 || illegal !== 0 || flags_valid !== 0 ||
            {flag_n, flag_z, flag_c, flag_v} !== 4'b0) begin
            n_fail++;
            $display("FAIL R1: rdy=%b rv=%b ill=%b fv=%b nzcv=%b expected all 0",
                     in_ready, res_valid, illegal, flags_valid, {flag_n, flag_z, flag_c, flag_v});
        end
        rst_n = 1;
        chk_en = 1;
        cur_tag = "R1";
        idle(2);
        issue(mk(4, 1, 1, 2, 3, 4));   // zero registers: no active lanes
        idle(2);

        // R11 / R9: preload, including dead high bits
        cur_tag = "R11";
        preload(1, 32'hFFFF_FFFF);
        preload(2, 32'h00A5_C3F0);
        preload(3, 32'h0F0F_0F0F);
        preload(4, 32'hFF00_FF00);
        preload(6, 32'h0000_0001);
        preload(7, 32'h0080_0000);
        preload(15, 32'h0);
        idle(1);

        // R3 / R4 / R7: every function, with and without flags
        for (int f = 0; f < 8; f++) begin
            cur_tag = (f == 3) ? "R4" : "R3";
            issue(mk(f, 0, 8, 2, 3, 4));
            issue(mk(f, 0, 9, 2, 3, 1));
            cur_tag = (f == 3) ? "R6" : "R7";
            issue(mk(f, 1, 10, 3, 2, 4));
            issue(mk(f, 1, 11, 2, 4, 6));
            issue(mk(f, 1, 12, 1, 2, 7));
            issue(mk(f, 1, 13, 1, 2, 15));
            idle(1);
        end
        // R2: field positions seen via distinct registers
        cur_tag = "R2";
        issue(mk(0, 0, 14, 1, 2, 1));
        issue(mk(2, 0, 5, 14, 3, 1));
        idle(2);

        // R8: destination is governing register
        cur_tag = "R8";
        preload(5, 32'h00F0_0F0F);
        issue(mk(6, 1, 5, 2, 3, 5));
        issue(mk(4, 1, 5, 5, 5, 5));
        idle(2);

        // R10: dependent back-to-back chain
        cur_tag = "R10";
        issue(mk(4, 0, 9, 2, 3, 1));
        issue(mk(2, 1, 9, 9, 4, 1));
        issue(mk(7, 1, 10, 9, 9, 9));
        issue(mk(4, 0, 11, 10, 10, 1));
        idle(2);

        // R5: broken fixed fields, then read back the target register
        cur_tag = "R5";
        issue(mk(4, 0, 8, 1, 1, 1) ^ 32'h0010_0000);
        issue(mk(4, 1, 8, 1, 1, 1) ^ 32'h0000_4000);
        issue(mk(4, 0, 8, 1, 1, 1) ^ 32'h8000_0000);
        issue(mk(4, 0, 12, 8, 8, 1));
        // R6: select with flags, then read back
        cur_tag = "R6";
        issue(mk(3, 1, 12, 1, 1, 1));
        issue(mk(4, 0, 13, 12, 12, 1));
        idle(2);

        // Mixed random traffic
        cur_tag = "R3";
        for (int it = 0; it < 600; it++) begin
            int sel = int'($urandom % 32);
            if (sel == 0) begin
                preload(int'($urandom % 16), $urandom);
            end else if (sel == 1) begin
                idle(1);
            end else begin
                logic [31:0] w = mk(int'($urandom % 8), 1'($urandom), int'($urandom % 16),
                                    int'($urandom % 16), int'($urandom % 16), int'($urandom % 16));
                if ($urandom % 25 == 0) w = w ^ (32'h1 << ($urandom % 3 == 0 ? 21 : 30));
                issue(w);
            end
        end
        idle(3);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule